// File: doc/BRIEF.md
# Endian-Selectable Load/Store Lane Aligner

This block sits between a 32-bit core and a data memory organised as four byte-wide lanes. Lane `k` of the memory word always holds the byte whose address has low bits equal to `k`. The core presents a request with a byte address, an access size (byte, halfword or word), a write flag, store data, a zero-extension request and a byte-order mode. The block turns it into a single-cycle memory port access: a word address, byte enables and lane-positioned store data.

Loads return their data one cycle after issue. The block takes the returned memory word and extracts the addressed bytes. It orders them according to the byte-order mode captured with the request, then sign- or zero-extends the result to 32 bits.

In big-endian mode the most significant byte of a multi-byte item goes to the lowest address. In little-endian mode the least significant byte goes there. For example, storing 0x87654321 at address 0 leaves bytes 87,65,43,21 at addresses 0..3 in big-endian mode and 21,43,65,87 in little-endian mode. A misaligned request is flagged and never reaches the memory.

Top module: `lsu_endian_port`

## Requirements
- R1: For an accepted request, `mem_addr` equals `req_addr` with its two low bits dropped. `mem_en` is high in the same cycle, and `mem_we` equals `req_write`.
- R2: Access size is encoded as 0 = byte, 1 = halfword, 2 = word, 3 = illegal. A request is misaligned when any of these holds: it is a word with `req_addr[1:0]` not 0; it is a halfword with `req_addr[0]` = 1; its size is 3. For a misaligned request, `req_err` is high in the same cycle, `mem_en` is low and `mem_be` is 0, so memory contents are left unchanged and no load response follows.
- R3: `mem_be` bit k enables lane k (`mem_wdata[8k+7:8k]`). A store enables only the lanes it addresses: one lane k = `req_addr[1:0]` for a byte, lanes 0-1 or 2-3 (chosen by `req_addr[1]`) for a halfword, and all four lanes for a word. Loads drive `mem_be` = 0.
- R4: With `req_big_endian` = 0, a store places store-data byte j (bits 8j+7:8j) at address base+j, where base is the access's lowest address.
- R5: With `req_big_endian` = 1, a store of an N-byte item places its most significant byte at the lowest address. Store-data byte N-1-j goes to address base+j.
- R6: A word load returns the four bytes at the word address, assembled in the byte order selected for that load.
- R7: A halfword load returns the two addressed bytes in the selected byte order.
- R8: A byte load returns the byte in lane `req_addr[1:0]`, whatever the byte-order mode.
- R9: By default, byte and halfword loads are sign-extended. With `req_unsigned` = 1 they are zero-extended.
- R10: `rsp_valid` is high exactly in the cycle after an accepted load, and `rsp_data` is valid in that cycle. Stores and misaligned requests produce no response.
- R11: The byte order and extension applied to a load response are those given with the load request, even if the mode inputs change in the response cycle.
- R12: While in reset and in the first cycle after it, with no request, `rsp_valid` and `mem_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_unsigned | input | 1 | Zero-extend sub-word loads |
| req_big_endian | input | 1 | 1 = big-endian, 0 = little-endian byte order |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| req_err | output | 1 | Misaligned or illegal request, access suppressed |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 4 | Per-lane byte enables |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | 32 | Lane-positioned store data |
| mem_rdata | input | 32 | Memory read word, one cycle after the read |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | 32 | Aligned, extended load result |

## Verification
A load's response is formed in the same cycle that the next request is being translated. A store can therefore be driving byte enables and lane data while the previous load's bytes are being unpacked. Requests are issued back to back with no idle cycle, and the byte-order mode flips between a load and the store that follows it. The store's lanes are checked combinationally in its own cycle. The scoreboard pops the load's expected value, built from a byte-addressed memory image in the order captured at issue, and compares it with the response in that same cycle.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int LSU_DATA_W = 32;
    localparam int LSU_LANES  = LSU_DATA_W / 8;
    localparam int LSU_OFF_W  = $clog2(LSU_LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic                 zext;
        logic                 big;
        acc_size_e            size;
        logic [LSU_OFF_W-1:0] off;
    } ld_desc_t;

    function automatic logic [LSU_DATA_W-1:0] swap_bytes(input logic [LSU_DATA_W-1:0] w);
        logic [LSU_DATA_W-1:0] r;
        for (int i = 0; i < LSU_LANES; i++) begin
            r[8*i +: 8] = w[8*(LSU_LANES-1-i) +: 8];
        end
        return r;
    endfunction

    function automatic logic [15:0] swap_half(input logic [15:0] h);
        return {h[7:0], h[15:8]};
    endfunction

    function automatic logic [LSU_LANES-1:0] lanes_of(input acc_size_e sz,
                                                      input logic [LSU_OFF_W-1:0] off);
        case (sz)
            SZ_BYTE: return LSU_LANES'(1) << off;
            SZ_HALF: return off[1] ? 4'b1100 : 4'b0011;
            SZ_WORD: return {LSU_LANES{1'b1}};
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
    import lsu_pkg::*;
(
    input  acc_size_e            size,
    input  logic [LSU_OFF_W-1:0] off,
    output logic                 misaligned
);
    always_comb begin
        case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = off[0];
            SZ_WORD: misaligned = (off != '0);
            default: misaligned = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
    import lsu_pkg::*;
(
    input  logic                  enable,
    input  acc_size_e             size,
    input  logic [LSU_OFF_W-1:0]  off,
    input  logic                  big,
    input  logic [LSU_DATA_W-1:0] data_in,
    output logic [LSU_LANES-1:0]  be,
    output logic [LSU_DATA_W-1:0] lane_data
);
    logic [15:0] half_ord;

    always_comb begin
        half_ord = big ? swap_half(data_in[15:0]) : data_in[15:0];
        case (size)
            SZ_BYTE: lane_data = {LSU_LANES{data_in[7:0]}};
            SZ_HALF: lane_data = {(LSU_LANES/2){half_ord}};
            SZ_WORD: lane_data = big ? swap_bytes(data_in) : data_in;
            default: lane_data = '0;
        endcase
        be = enable ? lanes_of(size, off) : '0;
    end
endmodule

// File: rtl/lsu_load_lane.sv
module lsu_load_lane
    import lsu_pkg::*;
(
    input  ld_desc_t              desc,
    input  logic [LSU_DATA_W-1:0] rdata,
    output logic [LSU_DATA_W-1:0] result
);
    logic [7:0] lane [LSU_LANES];
    logic [7:0]  sel_byte;
    logic [15:0] half_raw;
    logic [15:0] half_ord;
    logic        sgn;

    for (genvar g = 0; g < LSU_LANES; g++) begin : g_lane
        assign lane[g] = rdata[8*g +: 8];
    end

    always_comb begin
        sel_byte = lane[desc.off];
        half_raw = desc.off[1] ? rdata[31:16] : rdata[15:0];
        half_ord = desc.big ? swap_half(half_raw) : half_raw;
        sgn      = 1'b0;
        case (desc.size)
            SZ_BYTE: begin
                sgn    = ~desc.zext & sel_byte[7];
                result = {{(LSU_DATA_W-8){sgn}}, sel_byte};
            end
            SZ_HALF: begin
                sgn    = ~desc.zext & half_ord[15];
                result = {{(LSU_DATA_W-16){sgn}}, half_ord};
            end
            SZ_WORD: result = desc.big ? swap_bytes(rdata) : rdata;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/lsu_endian_port.sv
module lsu_endian_port
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [1:0]            req_size,
    input  logic                  req_unsigned,
    input  logic                  req_big_endian,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [LSU_DATA_W-1:0] req_wdata,
    output logic                  req_err,
    output logic                  mem_en,
    output logic                  mem_we,
    output logic [LSU_LANES-1:0]  mem_be,
    output logic [ADDR_W-LSU_OFF_W-1:0] mem_addr,
    output logic [LSU_DATA_W-1:0] mem_wdata,
    input  logic [LSU_DATA_W-1:0] mem_rdata,
    output logic                  rsp_valid,
    output logic [LSU_DATA_W-1:0] rsp_data
);
    acc_size_e            size_q;
    logic [LSU_OFF_W-1:0] off;
    logic                 misaligned;
    logic                 go;
    logic                 load_go;
    ld_desc_t             desc_d, desc_q;

    assign size_q = acc_size_e'(req_size);
    assign off    = req_addr[LSU_OFF_W-1:0];

    lsu_align_chk u_chk (
        .size       (size_q),
        .off        (off),
        .misaligned (misaligned)
    );

    assign req_err  = req_valid & misaligned;
    assign go       = req_valid & ~misaligned;
    assign load_go  = go & ~req_write;
    assign mem_en   = go;
    assign mem_we   = go & req_write;
    assign mem_addr = req_addr[ADDR_W-1:LSU_OFF_W];

    lsu_store_lane u_st (
        .enable    (go & req_write),
        .size      (size_q),
        .off       (off),
        .big       (req_big_endian),
        .data_in   (req_wdata),
        .be        (mem_be),
        .lane_data (mem_wdata)
    );

    always_comb begin
        desc_d.zext = req_unsigned;
        desc_d.big  = req_big_endian;
        desc_d.size = size_q;
        desc_d.off  = off;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            desc_q    <= '0;
        end else begin
            rsp_valid <= load_go;
            if (load_go) desc_q <= desc_d;
        end
    end

    lsu_load_lane u_ld (
        .desc   (desc_q),
        .rdata  (mem_rdata),
        .result (rsp_data)
    );

    // R2: a flagged request must not reach memory
    assert_err_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (!mem_en && mem_be == '0));

    // R3: enables only on stores, and in legal lane counts
    assert_be_store_only_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_be != '0) |-> (mem_en && mem_we));

    assert_be_count_R3: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                    $countones(mem_be) == 4));

    // R10: a response follows only an accepted read
    assert_rsp_after_load_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(mem_en && !mem_we));

    // R9: zero-extended byte result has clear upper bits
    assert_zext_byte_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && desc_q.zext && desc_q.size == SZ_BYTE) |-> (rsp_data[31:8] == '0));

endmodule

// File: tb/sim_lsu_endian_port.sv
module sim_lsu_endian_port;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_unsigned, req_big_endian;
    logic [1:0]  req_size;
    logic [31:0] req_addr, req_wdata;
    logic        req_err, mem_en, mem_we;
    logic [3:0]  mem_be;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        rsp_valid;
    logic [31:0] rsp_data;

    int checks = 0;
    int errors = 0;

    logic [7:0]  bmem  [64];
    logic [31:0] mword [16];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    lsu_endian_port #(.ADDR_W(32)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_unsigned(req_unsigned),
        .req_big_endian(req_big_endian), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_err(req_err), .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    // lane-organised memory model
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                for (int k = 0; k < 4; k++)
                    if (mem_be[k]) mword[mem_addr[3:0]][8*k +: 8] <= mem_wdata[8*k +: 8];
            end else begin
                mem_rdata <= mword[mem_addr[3:0]];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as responses appear
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected response", rsp_data, 32'h0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(rsp_data === e, t, rsp_data, e);
            end
        end
    end

    function automatic logic [31:0] exp_load(input logic [1:0] sz, input logic uns,
                                             input logic big, input logic [31:0] a);
        logic [7:0]  b0, b1, b2, b3;
        logic [15:0] h;
        b0 = bmem[a[5:0]];
        b1 = bmem[6'(a[5:0] + 1)];
        b2 = bmem[6'(a[5:0] + 2)];
        b3 = bmem[6'(a[5:0] + 3)];
        case (sz)
            2'd0: return uns ? {24'h0, b0} : {{24{b0[7]}}, b0};
            2'd1: begin
                h = big ? {b0, b1} : {b1, b0};
                return uns ? {16'h0, h} : {{16{h[15]}}, h};
            end
            default: return big ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
        endcase
    endfunction

    task automatic op(input logic wr, input logic [1:0] sz, input logic uns,
                      input logic big, input logic [31:0] a, input logic [31:0] d,
                      input string tag);
        logic        e_err;
        logic [3:0]  e_be;
        logic [31:0] e_lanes;
        int          n;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_unsigned = uns;
        req_big_endian = big; req_addr = a; req_wdata = d;
        #1;
        e_err = (sz == 2'd3) || (sz == 2'd2 && a[1:0] != 0) || (sz == 2'd1 && a[0]);
        chk(req_err === e_err, {"R2 err flag ", tag}, {31'h0, req_err}, {31'h0, e_err});
        if (e_err) begin
            chk(!mem_en && mem_be == 4'h0, {"R2 suppressed ", tag},
                {27'h0, mem_en, mem_be}, 32'h0);
        end else begin
            chk(mem_en && mem_we == wr && mem_addr == a[31:2], {"R1 address ", tag},
                {2'b0, mem_addr}, {2'b0, a[31:2]});
            if (wr) begin
                n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
                e_be = 4'h0; e_lanes = 32'h0;
                for (int j = 0; j < n; j++) begin
                    automatic int ad = a[5:0] + j;
                    automatic int sb = big ? (n - 1 - j) : j;
                    e_be[ad % 4] = 1'b1;
                    e_lanes[8*(ad % 4) +: 8] = d[8*sb +: 8];
                    bmem[ad] = d[8*sb +: 8];
                end
                chk(mem_be === e_be, {"R3 byte enables ", tag}, {28'h0, mem_be}, {28'h0, e_be});
                chk((mem_wdata & {{8{e_be[3]}}, {8{e_be[2]}}, {8{e_be[1]}}, {8{e_be[0]}}}) === e_lanes,
                    {big ? "R5 lanes " : "R4 lanes ", tag}, mem_wdata, e_lanes);
            end else begin
                chk(mem_be === 4'h0, {"R3 no enables on load ", tag}, {28'h0, mem_be}, 32'h0);
                exp_q.push_back(exp_load(sz, uns, big, a));
                tag_q.push_back({"R11 load ", tag});
            end
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        req_big_endian = ~req_big_endian; req_unsigned = ~req_unsigned;
    endtask

    initial begin
        #100000;
        chk(1'b0, "watchdog expired", 32'h0, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) bmem[i] = 8'(i * 37 + 5);
        for (int w = 0; w < 16; w++)
            mword[w] = {bmem[4*w+3], bmem[4*w+2], bmem[4*w+1], bmem[4*w]};
        mem_rdata = 32'h0;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
        req_unsigned = 1'b0; req_big_endian = 1'b0; req_addr = 32'h0; req_wdata = 32'h0;
        repeat (3) @(negedge clk);
        chk(rsp_valid === 1'b0 && mem_en === 1'b0, "R12 in reset", {31'h0, rsp_valid}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(rsp_valid === 1'b0 && mem_en === 1'b0, "R12 after reset", {31'h0, rsp_valid}, 32'h0);

        // R5 big-endian word store, R8 byte loads
        op(1, 2'd2, 0, 1, 32'd0, 32'h87654321, "R5 BE word store");
        for (int i = 0; i < 4; i++) op(0, 2'd0, 1, 1, 32'(i), 32'h0, "R8 byte load BE");
        // R4 little-endian word store, R9 sign extension
        op(1, 2'd2, 0, 0, 32'd4, 32'h87654321, "R4 LE word store");
        op(0, 2'd0, 0, 0, 32'd4, 32'h0, "R9 signed byte 0x21");
        op(0, 2'd0, 0, 0, 32'd7, 32'h0, "R9 signed byte 0x87");
        op(0, 2'd0, 1, 0, 32'd7, 32'h0, "R9 unsigned byte");
        // R6 word loads in both orders
        op(0, 2'd2, 0, 0, 32'd0, 32'h0, "R6 LE word load");
        op(0, 2'd2, 0, 1, 32'd0, 32'h0, "R6 BE word load");
        op(0, 2'd2, 0, 1, 32'd4, 32'h0, "R6 BE word load of LE data");
        // R7 halfwords
        op(1, 2'd1, 0, 1, 32'd10, 32'h0000BEEF, "R5 BE half store");
        op(1, 2'd1, 0, 0, 32'd8, 32'h00001234, "R4 LE half store");
        op(0, 2'd1, 0, 1, 32'd10, 32'h0, "R7 BE half signed");
        op(0, 2'd1, 1, 1, 32'd10, 32'h0, "R7 BE half unsigned");
        op(0, 2'd1, 0, 0, 32'd10, 32'h0, "R7 LE half of BE data");
        op(0, 2'd1, 0, 0, 32'd8, 32'h0, "R7 LE half");
        op(0, 2'd2, 0, 0, 32'd8, 32'h0, "R6 word over halves");
        // R2 misaligned requests leave memory untouched
        op(1, 2'd2, 0, 0, 32'd2, 32'hDEADDEAD, "R2 word misaligned store");
        op(1, 2'd1, 0, 1, 32'd5, 32'h0000DEAD, "R2 half misaligned store");
        op(1, 2'd3, 0, 0, 32'd12, 32'hDEADDEAD, "R2 illegal size store");
        op(0, 2'd2, 0, 0, 32'd1, 32'h0, "R2 word misaligned load");
        op(0, 2'd1, 0, 0, 32'd3, 32'h0, "R2 half misaligned load");
        op(0, 2'd2, 0, 1, 32'd0, 32'h0, "R2 word 0 unchanged");
        op(0, 2'd2, 0, 1, 32'd4, 32'h0, "R2 word 4 unchanged");
        op(0, 2'd2, 0, 0, 32'd12, 32'h0, "R2 word 12 unchanged");
        // R3 byte stores to every lane, R11 mode flips under pending responses
        for (int i = 0; i < 8; i++) begin
            op(1, 2'd0, 0, i[0], 32'(16 + i), 32'(8'hA0 + i), "R3 byte store lane");
            op(0, 2'd1, i[1], ~i[0], 32'(16 + (i & 6)), 32'h0, "R11 half after store");
        end
        for (int i = 0; i < 4; i++) begin
            op(0, 2'd2, 0, i[0], 32'(16 + 4*(i%2)), 32'h0, "R11 word alternating");
            op(1, 2'd2, 0, ~i[0], 32'(24 + 4*i), 32'(32'hC0FFEE00 + i), "R10 store during response");
        end
        for (int i = 0; i < 4; i++) op(0, 2'd2, 0, 1, 32'(24 + 4*i), 32'h0, "R6 readback");
        idle();
        chk(rsp_valid === 1'b1, "R10 last response present", {31'h0, rsp_valid}, 32'h1);
        idle();
        chk(rsp_valid === 1'b0, "R10 no response when idle", {31'h0, rsp_valid}, 32'h0);
        idle();
        chk(exp_q.size() == 0, "R10 all responses seen", 32'(exp_q.size()), 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule